// File: doc/BRIEF.md
# Complex Local-Mean Sifting Stage

This block performs one sifting pass on a two-channel (complex) sample stream. Each clock it can accept one complex input sample. Some fixed number of cycles later it can also accept a set of NENV complex envelope samples that belong to that same input sample. The upstream envelope generators all share one valid strobe. The stage adds up the envelopes for the real and the imaginary part separately and divides each total by NENV with rounding, which gives the complex local mean. It then subtracts that mean from a copy of the input that a shift-register line has held back by the envelope latency. The saturated 16-bit difference is the sifted output, and it feeds the next stage of a cascade.

When several of these stages are chained, the last one in a group delivers an intrinsic mode. For that case the stage has a residue path, selected by a parameter. This path subtracts an externally supplied mode sample from the stage input after a second, longer delay. The result is the input of the next decomposition group.

Top module: `sift_stage`

## Requirements
- R1: The local mean of each component is floor((S + NENV/2) / NENV), where S is the two's-complement sum of the NENV envelope samples of that component. This is round-half-up; with NENV = 8 it is an arithmetic shift right by 3.
- R2: Suppose an input sample is accepted at clock edge t and its envelopes at edge t+ENV_LAT. Then the sifted output after edge t+ENV_LAT+1 equals that input minus the local mean, computed separately for the real and imaginary parts.
- R3: Every subtraction result saturates to the range -32768..32767 and never wraps.
- R4: The sifted-valid output is high after edge e exactly when the envelope valid was high at edge e-1 and the input valid was high at edge e-1-ENV_LAT.
- R5: Suppose a mode sample is presented at edge e. Then the residue output after edge e equals the input accepted at edge e-RES_LAT minus that mode sample, saturated.
- R6: The residue-valid output is high after edge e exactly when the mode valid was high at edge e and the input valid was high at edge e-RES_LAT.
- R7: During reset, and whenever a valid output is low, its data outputs read zero. Data presented while its valid is low has no effect on any output.
- R8: With all valid inputs held high, the stage produces one valid result on every clock once the delay lines have filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Input sample valid |
| smp_re | input | DW | Input sample, real part (signed) |
| smp_im | input | DW | Input sample, imaginary part (signed) |
| env_vld | input | 1 | Common valid for all envelope samples |
| env_re | input | NENV*DW | Envelope real parts, envelope i in bits [i*DW +: DW] |
| env_im | input | NENV*DW | Envelope imaginary parts, same packing |
| sft_vld | output | 1 | Sifted output valid |
| sft_re | output | DW | Sifted output, real part |
| sft_im | output | DW | Sifted output, imaginary part |
| imf_vld | input | 1 | Mode sample valid (residue path) |
| imf_re | input | DW | Mode sample, real part |
| imf_im | input | DW | Mode sample, imaginary part |
| res_vld | output | 1 | Residue valid |
| res_re | output | DW | Residue, real part |
| res_im | output | DW | Residue, imaginary part |

## Verification
The sifted result depends on two stimuli applied at different times. The envelopes go in one edge before the result appears, and the input sample goes in ENV_LAT+1 edges before it. The residue, by contrast, appears after the same edge that takes the mode sample, and its input sample goes in RES_LAT edges earlier. The reference model records every applied stimulus by edge index. After edge e it rebuilds the expected outputs from the entries at e-1 and e-1-ENV_LAT for the sifted path, and at e and e-RES_LAT for the residue. It compares them on the falling edge that follows, so each comparison lands in the cycle where the register chain delivers its result.

// File: rtl/sift_pkg.sv
package sift_pkg;

   // true when n is a power of two and at least 2
   function automatic bit is_pow2(int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // choice of what the stage builds beside the sifting path
   typedef enum logic {
      SIFT_ONLY    = 1'b0,
      SIFT_AND_RES = 1'b1
   } sift_variant_e;

endpackage

// File: rtl/sift_dline.sv
module sift_dline #(
   parameter int W = 33,
   parameter int N = 43
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (N < 1) begin : g_bad_len
      $error("sift_dline: N must be at least 1");
   end

   if (N == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= '0;
         else        dout <= din;
      end
   end else begin : g_chain
      logic [W-1:0] stg [N];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < N; i++) stg[i] <= '0;
         end else begin
            stg[0] <= din;
            for (int i = 1; i < N; i++) stg[i] <= stg[i-1];
         end
      end
      assign dout = stg[N-1];
   end

endmodule

// File: rtl/sift_mean.sv
module sift_mean #(
   parameter int DW   = 16,
   parameter int NENV = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic [NENV*DW-1:0]   env,
   output logic                 mean_vld,
   output logic signed [DW-1:0] mean
);

   localparam int LG = $clog2(NENV);
   localparam int SW = DW + LG + 1;

   logic signed [SW-1:0] acc;
   logic signed [SW-1:0] rnd;
   logic signed [DW-1:0] mean_d;

   always_comb begin
      acc = '0;
      for (int i = 0; i < NENV; i++) begin
         acc = acc + SW'($signed(env[i*DW +: DW]));
      end
      rnd    = acc + SW'(NENV / 2);
      mean_d = DW'(rnd >>> LG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mean_vld <= 1'b0;
         mean     <= '0;
      end else begin
         mean_vld <= in_vld;
         mean     <= in_vld ? mean_d : '0;
      end
   end

endmodule

// File: rtl/sift_sub.sv
module sift_sub #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 a_vld,
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic                 b_vld,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   output logic                 q_vld,
   output logic signed [DW-1:0] q_re,
   output logic signed [DW-1:0] q_im
);

   localparam logic signed [DW:0] MAXV = {2'b00, {(DW-1){1'b1}}};
   localparam logic signed [DW:0] MINV = {2'b11, {(DW-1){1'b0}}};

   function automatic logic signed [DW-1:0] sat_sub(logic signed [DW-1:0] x,
                                                    logic signed [DW-1:0] y);
      logic signed [DW:0] d;
      d = (DW+1)'(x) - (DW+1)'(y);
      if (d > MAXV)      return DW'(MAXV);
      else if (d < MINV) return DW'(MINV);
      else               return DW'(d);
   endfunction

   logic both;
   assign both = a_vld & b_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld <= 1'b0;
         q_re  <= '0;
         q_im  <= '0;
      end else begin
         q_vld <= both;
         q_re  <= both ? sat_sub(a_re, b_re) : '0;
         q_im  <= both ? sat_sub(a_im, b_im) : '0;
      end
   end

endmodule

// File: rtl/sift_stage.sv
module sift_stage
   import sift_pkg::*;
#(
   parameter int            DW      = 16,
   parameter int            NENV    = 8,
   parameter int            ENV_LAT = 42,
   parameter int            RES_LAT = 220,
   parameter sift_variant_e VARIANT = SIFT_AND_RES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] smp_re,
   input  logic signed [DW-1:0] smp_im,
   input  logic                 env_vld,
   input  logic [NENV*DW-1:0]   env_re,
   input  logic [NENV*DW-1:0]   env_im,
   output logic                 sft_vld,
   output logic signed [DW-1:0] sft_re,
   output logic signed [DW-1:0] sft_im,
   input  logic                 imf_vld,
   input  logic signed [DW-1:0] imf_re,
   input  logic signed [DW-1:0] imf_im,
   output logic                 res_vld,
   output logic signed [DW-1:0] res_re,
   output logic signed [DW-1:0] res_im
);

   localparam int PW      = 2*DW + 1;
   localparam int SFT_LEN = ENV_LAT + 1;

   if (!is_pow2(NENV)) begin : g_bad_nenv
      $error("sift_stage: NENV must be a power of two, at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("sift_stage: DW must be at least 2");
   end
   if (ENV_LAT < 0 || RES_LAT < 1) begin : g_bad_lat
      $error("sift_stage: ENV_LAT >= 0 and RES_LAT >= 1 required");
   end

   // packed input word: {valid, re, im}
   logic [PW-1:0] smp_word;
   assign smp_word = {smp_vld, smp_re, smp_im};

   // sifting path: delayed input vs. local mean
   logic [PW-1:0] sft_dly;
   sift_dline #(.W(PW), .N(SFT_LEN)) u_sft_dly (
      .clk(clk), .rst_n(rst_n), .din(smp_word), .dout(sft_dly)
   );

   logic                 mre_vld, mim_vld;
   logic signed [DW-1:0] mre, mim;

   sift_mean #(.DW(DW), .NENV(NENV)) u_mean_re (
      .clk(clk), .rst_n(rst_n), .in_vld(env_vld), .env(env_re),
      .mean_vld(mre_vld), .mean(mre)
   );
   sift_mean #(.DW(DW), .NENV(NENV)) u_mean_im (
      .clk(clk), .rst_n(rst_n), .in_vld(env_vld), .env(env_im),
      .mean_vld(mim_vld), .mean(mim)
   );

   sift_sub #(.DW(DW)) u_sft_sub (
      .clk(clk), .rst_n(rst_n),
      .a_vld(sft_dly[PW-1]), .a_re(sft_dly[2*DW-1:DW]), .a_im(sft_dly[DW-1:0]),
      .b_vld(mre_vld & mim_vld), .b_re(mre), .b_im(mim),
      .q_vld(sft_vld), .q_re(sft_re), .q_im(sft_im)
   );

   // residue path, built only in the companion variant
   if (VARIANT == SIFT_AND_RES) begin : g_res
      logic [PW-1:0] res_dly;
      sift_dline #(.W(PW), .N(RES_LAT)) u_res_dly (
         .clk(clk), .rst_n(rst_n), .din(smp_word), .dout(res_dly)
      );
      sift_sub #(.DW(DW)) u_res_sub (
         .clk(clk), .rst_n(rst_n),
         .a_vld(res_dly[PW-1]), .a_re(res_dly[2*DW-1:DW]), .a_im(res_dly[DW-1:0]),
         .b_vld(imf_vld), .b_re(imf_re), .b_im(imf_im),
         .q_vld(res_vld), .q_re(res_re), .q_im(res_im)
      );
   end else begin : g_no_res
      assign res_vld = 1'b0;
      assign res_re  = '0;
      assign res_im  = '0;
   end

endmodule

// File: rtl/sift_stage_chk.sv
module sift_stage_chk #(
   parameter int DW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 env_vld,
   input logic                 sft_vld,
   input logic signed [DW-1:0] sft_re,
   input logic signed [DW-1:0] sft_im,
   input logic                 imf_vld,
   input logic signed [DW-1:0] imf_re,
   input logic                 res_vld,
   input logic signed [DW-1:0] res_re,
   input logic signed [DW-1:0] res_im
);

   localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

   AST_SFT_NEEDS_ENV: assert property (@(posedge clk) disable iff (!rst_n)
      sft_vld |-> $past(env_vld, 2)); // R4

   AST_RES_NEEDS_IMF: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(imf_vld)); // R6

   AST_SFT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !sft_vld |-> (sft_re == '0 && sft_im == '0)); // R7

   AST_RES_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> (res_re == '0 && res_im == '0)); // R7

   AST_RES_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && $past(imf_re) == SMIN) |-> (res_re >= 0)); // R3

   AST_RES_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && $past(imf_re) == SMAX) |-> (res_re <= 0)); // R3

endmodule

bind sift_stage sift_stage_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .env_vld(env_vld),
   .sft_vld(sft_vld), .sft_re(sft_re), .sft_im(sft_im),
   .imf_vld(imf_vld), .imf_re(imf_re),
   .res_vld(res_vld), .res_re(res_re), .res_im(res_im)
);

// File: tb/sim_sift_stage.sv
`timescale 1ns/1ps
module sim_sift_stage;

   localparam int DW   = 16;
   localparam int NE   = 8;
   localparam int ELAT = 42;
   localparam int RLAT = 220;
   localparam int NCYC = 1500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                 smp_vld = 1'b0, env_vld = 1'b0, imf_vld = 1'b0;
   logic signed [DW-1:0] smp_re = '0, smp_im = '0, imf_re = '0, imf_im = '0;
   logic [NE*DW-1:0]     env_re = '0, env_im = '0;
   logic                 sft_vld, res_vld;
   logic signed [DW-1:0] sft_re, sft_im, res_re, res_im;

   sift_stage u0 (
      .clk(clk), .rst_n(rst_n),
      .smp_vld(smp_vld), .smp_re(smp_re), .smp_im(smp_im),
      .env_vld(env_vld), .env_re(env_re), .env_im(env_im),
      .sft_vld(sft_vld), .sft_re(sft_re), .sft_im(sft_im),
      .imf_vld(imf_vld), .imf_re(imf_re), .imf_im(imf_im),
      .res_vld(res_vld), .res_re(res_re), .res_im(res_im)
   );

   // stimulus history by edge index
   bit    hz_v[NCYC], he_v[NCYC], hi_v[NCYC];
   int    hz_re[NCYC], hz_im[NCYC], hi_re[NCYC], hi_im[NCYC];
   int    hm_re[NCYC], hm_im[NCYC];
   string htag[NCYC];

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   function automatic int fdiv(int s, int d);
      return (s >= 0) ? s / d : -(((-s) + d - 1) / d);
   endfunction

   function automatic int sat(int x);
      return (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
   endfunction

   function automatic int rnd(int lo, int hi);
      return lo + int'($urandom % (hi - lo + 1));
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // compare the outputs present after edge e with the reference model
   task automatic check_edge(int e);
      bit ev, rv;
      int er = 0, ei = 0, rr = 0, ri = 0;
      string t;
      ev = (e - 1 - ELAT >= 0) && hz_v[e-1-ELAT] && he_v[e-1];
      t  = (e >= 1) ? htag[e-1] : "R7";
      if (ev) begin
         er = sat(hz_re[e-1-ELAT] - hm_re[e-1]);
         ei = sat(hz_im[e-1-ELAT] - hm_im[e-1]);
      end
      chk((t == "R2") ? "R8" : "R4", "sft_vld", int'(sft_vld), int'(ev));
      chk(ev ? t : "R7", "sft_re", int'(sft_re), er);
      chk(ev ? t : "R7", "sft_im", int'(sft_im), ei);
      rv = (e - RLAT >= 0) && hz_v[e-RLAT] && hi_v[e];
      if (rv) begin
         rr = sat(hz_re[e-RLAT] - hi_re[e]);
         ri = sat(hz_im[e-RLAT] - hi_im[e]);
      end
      chk("R6", "res_vld", int'(res_vld), int'(rv));
      chk(rv ? "R5" : "R7", "res_re", int'(res_re), rr);
      chk(rv ? "R5" : "R7", "res_im", int'(res_im), ri);
   endtask

   task automatic drive(int k);
      int ere[NE], eim[NE];
      int sre = 0, sim = 0;
      string t;
      bit zv, evl, ivl;
      int zr, zi, ir, ii;
      zv = 1'b1; evl = 1'b1; ivl = 1'b1;
      zr = rnd(-20000, 20000); zi = rnd(-20000, 20000);
      ir = rnd(-8000, 8000);   ii = rnd(-8000, 8000);
      for (int i = 0; i < NE; i++) begin
         ere[i] = rnd(-4000, 4000); eim[i] = rnd(-4000, 4000);
      end
      if (k < 300) t = "R2";
      else if (k < 500) t = "R1";
      else if (k < 600) t = "R3";
      else if (k < 1300) t = "R4";
      else t = "R7";
      if (k >= 300 - ELAT && k < 500) begin zr = 0; zi = 0; end
      if (t == "R1") begin
         // small sums across every remainder, both signs, incl. exact halves
         for (int i = 0; i < NE; i++) begin ere[i] = 0; eim[i] = 0; end
         ere[0] = (k % 25) - 12;
         eim[0] = 12 - (k % 25);
         if (k % 2 == 1) begin ere[1] = -(k % 7); eim[2] = k % 5; end
      end
      if (k >= 500 - ELAT && k < 600) begin
         zr = (k % 2 == 1) ? 32767 : -32768;
         zi = -zr - 1;
      end
      if (t == "R3") begin
         for (int i = 0; i < NE; i++) begin
            ere[i] = (hz_re[k-ELAT] > 0) ? -32768 : 32767;
            eim[i] = (hz_im[k-ELAT] > 0) ? -32768 : 32767;
         end
         ir = (k % 2 == 1) ? -32768 : 32767;
         ii = -ir - 1;
      end
      if (t == "R4") begin
         zv = 1'($urandom); evl = 1'($urandom); ivl = 1'($urandom);
         zr = rnd(-32768, 32767); zi = rnd(-32768, 32767);
         ir = rnd(-32768, 32767); ii = rnd(-32768, 32767);
      end
      if (t == "R7") begin zv = 1'b0; evl = 1'b0; ivl = 1'b0; end
      for (int i = 0; i < NE; i++) begin sre += ere[i]; sim += eim[i]; end
      // record stimulus; data with valid low is stored but never used
      hz_v[k] = zv; he_v[k] = evl; hi_v[k] = ivl;
      hz_re[k] = zr; hz_im[k] = zi; hi_re[k] = ir; hi_im[k] = ii;
      hm_re[k] = fdiv(sre + NE/2, NE); hm_im[k] = fdiv(sim + NE/2, NE);
      htag[k] = t;
      smp_vld = zv; smp_re = DW'(zr); smp_im = DW'(zi);
      env_vld = evl; imf_vld = ivl; imf_re = DW'(ir); imf_im = DW'(ii);
      for (int i = 0; i < NE; i++) begin
         env_re[i*DW +: DW] = DW'(ere[i]);
         env_im[i*DW +: DW] = DW'(eim[i]);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state
      chk("R7", "reset sft_vld", int'(sft_vld), 0);
      chk("R7", "reset sft_re", int'(sft_re), 0);
      chk("R7", "reset res_vld", int'(res_vld), 0);
      chk("R7", "reset res_im", int'(res_im), 0);
      rst_n = 1'b1;
      for (int k = 0; k < NCYC; k++) begin
         if (k > 0) check_edge(k - 1);
         drive(k);
         @(posedge clk);
         @(negedge clk);
      end
      check_edge(NCYC - 1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule